// File: doc/BRIEF.md
# Hot-Swap Short-Circuit Retry Controller

This block decides when the gate of a hot-swap power switch may be driven on again after an overcurrent or hard short. A qualified fault input, which is already filtered by the analog front end, turns the gate off at once. The block then waits a programmable number of millisecond ticks and re-enables the gate for a short observation window. If the fault comes back inside that window, the attempt counts as a failed retry. The block waits again and tries once more, up to a limit chosen by a 3-bit mode field.

When the limit is used up, the block enters a latched lockout. In lockout the gate stays off, an active-low failure pin goes low and a failure status bit reads 1. Only the active-low master-reset input or the power-on reset clears the lockout. The unlimited mode never locks out: it keeps retrying until the fault goes away, and then the gate stays on. The count of failed retries in the current episode is available on an output port. The retry mode and the delay select are plain input ports and take effect immediately.

Top module: `hs_retry_ctrl`

## Requirements
- R1: After `rst` has been high for a clock edge, `gate_en`=1, `fail_n`=1, `fail_stat`=0 and `retry_cnt`=0.
- R2: A fault seen while the gate is on turns `gate_en` off at the next clock edge. The gate stays off for a delay of tick pulses selected by `dly_sel`: 00 = 100, 01 = 500, 10 = 1000, 11 = 5000. After that delay the gate is driven on again for a probe.
- R3: The off-delay advances only on clock edges where `tick` is high. While `tick` is low, the delay is frozen.
- R4: A probe whose 1-tick observation window passes with no fault returns the block to normal operation. In normal operation `gate_en` stays 1 and `retry_cnt` is cleared to 0.
- R5: A fault during a probe turns the gate off again, adds 1 to `retry_cnt` and starts a new off-delay.
- R6: The retry modes are: `retry_mode` 000 = 0 retries, 001 = 1, 010 = 2, 011 = 4, 100 = 8, 101 = 16, 110 = 32, 111 = unlimited. When the failed-retry count reaches the limit, the block enters lockout with `gate_en`=0, `fail_n`=0 and `fail_stat`=1. In mode 000 the first fault leads straight to lockout.
- R7: Lockout is sticky. It persists after the fault clears and while ticks keep arriving.
- R8: In mode 111 the block never enters lockout. Once the fault clears, the next probe succeeds and the gate stays on.
- R9: `retry_cnt` saturates at 63.
- R10: `mr_n` low at a clock edge clears lockout and the retry count. The outputs then match the R1 reset state.
- R11: `rst` high at a clock edge clears lockout and the retry count in the same way as `mr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mr_n | input | 1 | Synchronous active-low master reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| fault | input | 1 | Qualified overcurrent / short indication |
| retry_mode | input | 3 | Retry limit select (see R6) |
| dly_sel | input | 2 | Off-delay select (see R2) |
| gate_en | output | 1 | Power-switch gate enable |
| fail_n | output | 1 | Active-low failure-after-retry pin |
| fail_stat | output | 1 | Failure status bit, 1 in lockout |
| retry_cnt | output | 6 | Failed retries in the current episode |

## Verification
The bench holds `tick` high on every clock edge, so each delay lasts exactly one clock cycle per tick. Inputs change on the falling edge.

Counting falling edges from the one where a fault is raised, `gate_en` falls at edge 1 and rises again at edge D+1 for a delay of D ticks. Each failed retry of a held fault takes 101 further cycles, so lockout for a limit L appears at edge 1+101·L. Resets take effect at the very next edge. During the tick-gating test the bench adds the number of tickless cycles to these due times.

All outputs are sampled only at those falling edges, and the bench compares the measured count against these formulas.

// File: rtl/hs_retry_pkg.sv
package hs_retry_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PROBE = 2'd2,
        ST_LOCK  = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] dsel;
    } hs_cfg_t;

    // Number of failed retries allowed before lockout (0 for unlimited mode too).
    function automatic int retry_limit(input logic [2:0] m);
        if (m == 3'd0 || m == 3'd7) return 0;
        return 1 << (int'(m) - 1);
    endfunction

    function automatic logic retry_unlimited(input logic [2:0] m);
        return (m == 3'b111);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int r;
        r = a;
        if (b > r) r = b;
        if (c > r) r = c;
        if (d > r) r = d;
        return r;
    endfunction

endpackage

// File: rtl/hs_retry_timer.sv
module hs_retry_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = tick && (cnt == target - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R3: without a tick the elapsed count does not move
    assert_tick_only_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/hs_retry_count.sv
module hs_retry_count #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [2:0]   mode,
    output logic [W-1:0] cnt,
    output logic         last
);
    import hs_retry_pkg::*;

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // The failure now being counted reaches the programmed limit.
    assign last = !retry_unlimited(mode) && ((int'(cnt) + 1) >= retry_limit(mode));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/hs_retry_ctrl.sv
module hs_retry_ctrl #(
    parameter int DLY0_MS = 100,
    parameter int DLY1_MS = 500,
    parameter int DLY2_MS = 1000,
    parameter int DLY3_MS = 5000,
    parameter int OBS_MS  = 1,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mr_n,
    input  logic             tick,
    input  logic             fault,
    input  logic [2:0]       retry_mode,
    input  logic [1:0]       dly_sel,
    output logic             gate_en,
    output logic             fail_n,
    output logic             fail_stat,
    output logic [CNT_W-1:0] retry_cnt
);
    import hs_retry_pkg::*;

    localparam int DLY_MAX = max4(DLY0_MS, DLY1_MS, DLY2_MS, DLY3_MS);
    localparam int TW      = $clog2(((DLY_MAX > OBS_MS) ? DLY_MAX : OBS_MS) + 1);

    hs_state_e    state, nxt;
    hs_cfg_t      cfg;
    logic         hard_clr;
    logic         t_done, t_clr;
    logic [TW-1:0] t_target, dly_ticks;
    logic         c_inc, c_clr, c_last;

    assign hard_clr = rst || !mr_n;
    assign cfg      = '{mode: retry_mode, dsel: dly_sel};

    always_comb begin
        unique case (cfg.dsel)
            2'd0:    dly_ticks = TW'(DLY0_MS);
            2'd1:    dly_ticks = TW'(DLY1_MS);
            2'd2:    dly_ticks = TW'(DLY2_MS);
            default: dly_ticks = TW'(DLY3_MS);
        endcase
    end

    assign t_target = (state == ST_PROBE) ? TW'(OBS_MS) : dly_ticks;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (fault) begin
                    if (!retry_unlimited(cfg.mode) && retry_limit(cfg.mode) == 0)
                        nxt = ST_LOCK;
                    else
                        nxt = ST_WAIT;
                end
            end
            ST_WAIT:  if (t_done) nxt = ST_PROBE;
            ST_PROBE: begin
                if (fault)       nxt = c_last ? ST_LOCK : ST_WAIT;
                else if (t_done) nxt = ST_RUN;
            end
            default:  nxt = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hard_clr) state <= ST_RUN;
        else          state <= nxt;
    end

    assign t_clr = (nxt != state);
    assign c_inc = (state == ST_PROBE) && fault;
    assign c_clr = (state == ST_PROBE) && !fault && t_done;

    hs_retry_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst    (hard_clr),
        .clr    (t_clr),
        .tick   (tick),
        .target (t_target),
        .done   (t_done)
    );

    hs_retry_count #(.W(CNT_W)) u_count (
        .clk  (clk),
        .rst  (hard_clr),
        .clr  (c_clr),
        .inc  (c_inc),
        .mode (cfg.mode),
        .cnt  (retry_cnt),
        .last (c_last)
    );

    assign gate_en   = (state == ST_RUN) || (state == ST_PROBE);
    assign fail_stat = (state == ST_LOCK);
    assign fail_n    = !fail_stat;

    assert_gate_drop_R2: assert property (@(posedge clk) disable iff (hard_clr)
        (gate_en && fault) |=> !gate_en);

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (hard_clr)
        fail_stat |=> (fail_stat && !gate_en));

    assert_unlimited_no_lock_R8: assert property (@(posedge clk) disable iff (hard_clr)
        (retry_mode == 3'b111 && !fail_stat) |=> !fail_stat);

    assert_mr_clears_R10: assert property (@(posedge clk) disable iff (rst)
        !mr_n |=> (gate_en && fail_n && retry_cnt == '0));

endmodule

// File: tb/tb_hs_retry_ctrl.sv
module tb_hs_retry_ctrl;

    logic       clk = 1'b0;
    logic       rst, mr_n, tick, fault;
    logic [2:0] retry_mode;
    logic [1:0] dly_sel;
    logic       gate_en, fail_n, fail_stat;
    logic [5:0] retry_cnt;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    hs_retry_ctrl dut (
        .clk(clk), .rst(rst), .mr_n(mr_n), .tick(tick), .fault(fault),
        .retry_mode(retry_mode), .dly_sel(dly_sel),
        .gate_en(gate_en), .fail_n(fail_n), .fail_stat(fail_stat),
        .retry_cnt(retry_cnt)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic mr_pulse();
        mr_n = 1'b0;
        @(negedge clk);
        mr_n = 1'b1;
    endtask

    function automatic int lim_of(input int m);
        return 1 << (m - 1);
    endfunction

    function automatic int dly_of(input int d);
        case (d)
            0: return 100;
            1: return 500;
            2: return 1000;
            default: return 5000;
        endcase
    endfunction

    task automatic t_reset();
        chk("R1 gate_en", gate_en, 1);
        chk("R1 fail_n", fail_n, 1);
        chk("R1 fail_stat", fail_stat, 0);
        chk("R1 retry_cnt", retry_cnt, 0);
    endtask

    task automatic t_delays();
        int n;
        retry_mode = 3'b010;
        for (int d = 0; d < 4; d++) begin
            dly_sel = 2'(d);
            fault = 1'b1;
            @(negedge clk);
            fault = 1'b0;
            n = 1;
            chk("R2 gate off after fault", gate_en, 0);
            while (!gate_en && n < 6000) begin
                @(negedge clk);
                n++;
            end
            chk($sformatf("R2 off period sel %0d", d), n, dly_of(d) + 1);
            repeat (2) @(negedge clk);
            chk("R4 gate stays on after clean probe", gate_en, 1);
            chk("R4 count cleared", retry_cnt, 0);
        end
        dly_sel = 2'd0;
    endtask

    task automatic t_tick_pause();
        int n;
        retry_mode = 3'b010;
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        n = 1;
        while (n < 50) begin
            @(negedge clk);
            n++;
        end
        tick = 1'b0;
        repeat (300) begin
            @(negedge clk);
            n++;
        end
        chk("R3 gate held off while ticks stop", gate_en, 0);
        tick = 1'b1;
        while (!gate_en && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 off period stretched by tickless cycles", n, 401);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_fail_then_ok();
        retry_mode = 3'b010;
        fault = 1'b1;
        repeat (150) @(negedge clk);
        chk("R5 count after one failed probe", retry_cnt, 1);
        chk("R5 gate off after failed probe", gate_en, 0);
        chk("R5 not locked", fail_n, 1);
        fault = 1'b0;
        repeat (53) @(negedge clk);
        chk("R4 gate on after clean probe", gate_en, 1);
        chk("R4 count cleared on success", retry_cnt, 0);
        repeat (50) @(negedge clk);
        chk("R4 gate remains on", gate_en, 1);
    endtask

    task automatic t_limits();
        int n;
        for (int m = 1; m < 7; m++) begin
            retry_mode = 3'(m);
            fault = 1'b1;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (fail_n && n < 4000);
            chk($sformatf("R6 lockout time mode %0d", m), n, 1 + 101 * lim_of(m));
            chk($sformatf("R6 count at lockout mode %0d", m), retry_cnt, lim_of(m));
            chk("R6 gate off in lockout", gate_en, 0);
            chk("R6 fail_stat in lockout", fail_stat, 1);
            fault = 1'b0;
            mr_pulse();
            chk("R10 gate back after master reset", gate_en, 1);
            chk("R10 fail_n released", fail_n, 1);
            chk("R10 status cleared", fail_stat, 0);
            chk("R10 count cleared", retry_cnt, 0);
        end
    endtask

    task automatic t_mode0_sticky();
        retry_mode = 3'b000;
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        chk("R6 mode 000 locks on first fault", fail_n, 0);
        chk("R6 mode 000 count", retry_cnt, 0);
        repeat (500) @(negedge clk);
        chk("R7 lockout gate stays off", gate_en, 0);
        chk("R7 lockout status stays set", fail_stat, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 power-on reset clears lockout", fail_n, 1);
        chk("R11 gate back after reset", gate_en, 1);
    endtask

    task automatic t_unlimited();
        int n;
        retry_mode = 3'b111;
        fault = 1'b1;
        repeat (7070) @(negedge clk);
        chk("R8 no lockout in unlimited mode", fail_n, 1);
        chk("R9 count saturates at 63", retry_cnt, 63);
        fault = 1'b0;
        n = 0;
        while (!gate_en && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk("R8 gate on once fault clears", gate_en, 1);
        chk("R8 status clear", fail_stat, 0);
        chk("R8 count cleared after success", retry_cnt, 0);
    endtask

    initial begin
        rst = 1'b1; mr_n = 1'b1; tick = 1'b1; fault = 1'b0;
        retry_mode = 3'b000; dly_sel = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_delays();
        t_tick_pause();
        t_fail_then_ok();
        t_limits();
        t_mode0_sticky();
        t_unlimited();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule